// File: doc/BRIEF.md
# Per-Sector CRC Insert and Check

This stage sits in the byte-wide data path of a flash controller, between the host-side buffer and the error-correction encoder or decoder. In the write direction it runs a 64-bit CRC over the payload bytes of each sector as they pass. Directly after the last payload byte it emits the eight CRC bytes, so the CRC is stored in the flash with the data. There is no gap on either side, and any ECC redundancy comes after the CRC.

In the read direction the payload is forwarded unchanged while the CRC is recomputed. The eight stored CRC bytes that follow each sector are taken off the stream and compared with the fresh value. A mismatch raises a sticky integrity-error flag and sends a one-cycle request to reset the controller's thread.

On both input and output, a byte moves on a cycle where valid and ready are both high. The input sector marker always flags the last payload byte. On the write output, that marker moves to the eighth CRC byte. Protection can be switched on or off, and the direction changed, only between sectors.

Top module: `sec_crc_stage`

## Requirements
- R1: After reset the stage is disabled and in write direction, `errFlag` and `rstReq` are low, and `outValid` is low while `inValid` is low.
- R2: While disabled, every input byte is passed to the output unchanged, with its `inLast` copied to `outLast`, and no byte is added or removed.
- R3: Enabled in write direction (`rdReq`=0), the payload bytes are forwarded unchanged with `outLast` low. Exactly 8 CRC bytes follow at once, most significant byte first. `outLast` is high only on the eighth CRC byte, and `inReady` stays low while the CRC bytes are emitted.
- R4: The CRC uses polynomial 0x42F0E1EBA9EA3693, starts at all ones, and shifts each byte in most significant bit first. There is no final inversion. It starts again at all ones for every sector, so the 9 ASCII bytes "123456789" give 0x9D13A61C0E5B0FF5.
- R5: Enabled in read direction (`rdReq`=1), the payload bytes are forwarded with `outLast` on the last payload byte. The next 8 input bytes are accepted (`inReady` high) and are never forwarded (`outValid` low).
- R6: In read direction, when the 8 received bytes equal the recomputed CRC (most significant first), `errFlag` and `rstReq` stay low.
- R7: In read direction, any difference in the 8 received CRC bytes sets `errFlag` and raises `rstReq`. Both are high in the cycle after the clock edge that accepts the eighth CRC byte, and `rstReq` is high for exactly that one cycle.
- R8: `errFlag` stays high until `errClr` is asserted. It is low in the cycle after a cycle with `errClr` high, unless a new mismatch completes at that same edge.
- R9: `enReq` and `rdReq` take effect only while no sector is in progress. A change made after a sector's first byte and before its CRC bytes finish has no effect on that sector.
- R10: While a write-direction CRC byte is offered and `outReady` is low, `outValid` stays high and `outData` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enReq | input | 1 | Requested CRC protection enable, sampled between sectors |
| rdReq | input | 1 | Requested direction, 1 = read/check and 0 = write/insert, sampled between sectors |
| errClr | input | 1 | Clears the sticky error flag |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inLast | input | 1 | Marks the last payload byte of a sector |
| inReady | output | 1 | Stage accepts the input byte |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Marks the last byte of a sector on the output |
| outReady | input | 1 | Downstream accepts the output byte |
| errFlag | output | 1 | Sticky data-path integrity error |
| rstReq | output | 1 | One-cycle thread reset request |

## Verification
The payload path adds no latency: each output byte, together with its `outLast`, is sampled at the falling edge that comes before the rising edge that moves it. The first CRC byte therefore appears at the first falling edge after the edge that accepted the last payload byte, and one CRC byte follows per accepted cycle after that. The error flag and reset request are due one edge after the eighth CRC byte is accepted: they are sampled at the next falling edge, and the following falling edge confirms that `rstReq` has dropped. The configuration latch needs one idle edge, so each test that changes `enReq` or `rdReq` waits two idle cycles before its first byte. The mid-sector test changes both inputs between bytes and checks that the sector keeps its original treatment.

// File: rtl/sec_crc_pkg.sv
package sec_crc_pkg;
  localparam int BYTE_W    = 8;
  localparam int CRC_W     = 64;
  localparam int CRC_BYTES = CRC_W / BYTE_W;
  localparam int IDX_W     = $clog2(CRC_BYTES);

  // strobes from control to datapath
  typedef struct packed {
    logic             init;    // restart the CRC for the next sector
    logic             step;    // fold the current input byte into the CRC
    logic             emit;    // write tail: output carries a CRC byte
    logic             absorb;  // read tail: input carries a stored CRC byte
    logic [IDX_W-1:0] idx;     // CRC byte index, 0 = most significant
  } crcStrb_t;

  function automatic logic [CRC_W-1:0] crcFoldByte(
    input logic [CRC_W-1:0]  cur,
    input logic [BYTE_W-1:0] din,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] r;
    r = cur ^ {din, {(CRC_W-BYTE_W){1'b0}}};
    for (int b = 0; b < BYTE_W; b++) begin
      r = r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/sec_crc_dpath.sv
module sec_crc_dpath
  import sec_crc_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 64'h42F0E1EBA9EA3693,
  parameter logic [CRC_W-1:0] SEED = {CRC_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrb_t          strb,
  input  logic [BYTE_W-1:0] inData,
  output logic [BYTE_W-1:0] crcByte,
  output logic              byteMismatch
);
  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcShifted;

  always_ff @(posedge clk) begin
    if (!rstN || strb.init) begin
      crcReg <= SEED;
    end else if (strb.step) begin
      crcReg <= crcFoldByte(crcReg, inData, POLY);
    end
  end

  always_comb begin
    crcShifted   = crcReg << {strb.idx, 3'b000};
    crcByte      = crcShifted[CRC_W-1 -: BYTE_W];
    byteMismatch = (inData != crcByte);
  end
endmodule

// File: rtl/sec_crc_ctrl.sv
module sec_crc_ctrl
  import sec_crc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enReq,
  input  logic     rdReq,
  input  logic     errClr,
  input  logic     inValid,
  input  logic     inLast,
  output logic     inReady,
  output logic     outValid,
  output logic     outLast,
  input  logic     outReady,
  input  logic     byteMismatch,
  output crcStrb_t strb,
  output logic     errFlag,
  output logic     rstReq
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CRC_BYTES - 1);

  typedef enum logic {ST_DATA, ST_TAIL} phase_t;

  phase_t           phase;
  logic [IDX_W-1:0] tailCnt;
  logic             inSector;
  logic             cfgEn;
  logic             cfgRd;
  logic             mismSeen;

  logic tail, emit, absorb, dataFire, tailFire, tailDone, idle;

  always_comb begin
    tail     = (phase == ST_TAIL);
    emit     = tail && !cfgRd;
    absorb   = tail && cfgRd;
    inReady  = tail ? absorb : outReady;
    outValid = tail ? emit : inValid;
    outLast  = emit ? (tailCnt == LAST_IDX)
                    : (!tail && inLast && !(cfgEn && !cfgRd));
    dataFire = !tail && inValid && outReady;
    tailFire = emit ? outReady : (absorb && inValid);
    tailDone = tailFire && (tailCnt == LAST_IDX);
    idle     = !tail && !inSector;

    strb.init   = tailDone;
    strb.step   = dataFire && cfgEn;
    strb.emit   = emit;
    strb.absorb = absorb;
    strb.idx    = tailCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= ST_DATA;
      tailCnt  <= '0;
      inSector <= 1'b0;
      cfgEn    <= 1'b0;
      cfgRd    <= 1'b0;
      mismSeen <= 1'b0;
      errFlag  <= 1'b0;
      rstReq   <= 1'b0;
    end else begin
      rstReq <= 1'b0;
      if (errClr) errFlag <= 1'b0;

      if (idle && !dataFire) begin
        cfgEn <= enReq;
        cfgRd <= rdReq;
      end

      if (dataFire) begin
        inSector <= !inLast;
        if (inLast && cfgEn) begin
          phase   <= ST_TAIL;
          tailCnt <= '0;
        end
      end

      if (tailFire) begin
        tailCnt <= tailCnt + 1'b1;
        if (absorb) mismSeen <= mismSeen || byteMismatch;
        if (tailDone) begin
          phase    <= ST_DATA;
          mismSeen <= 1'b0;
          if (absorb && (mismSeen || byteMismatch)) begin
            errFlag <= 1'b1;
            rstReq  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sec_crc_stage.sv
module sec_crc_stage
  import sec_crc_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 64'h42F0E1EBA9EA3693,
  parameter logic [CRC_W-1:0] SEED = {CRC_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enReq,
  input  logic              rdReq,
  input  logic              errClr,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outLast,
  input  logic              outReady,
  output logic              errFlag,
  output logic              rstReq
);
  crcStrb_t          strb;
  logic [BYTE_W-1:0] crcByte;
  logic              byteMismatch;

  sec_crc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enReq(enReq), .rdReq(rdReq), .errClr(errClr),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .outValid(outValid), .outLast(outLast), .outReady(outReady),
    .byteMismatch(byteMismatch), .strb(strb),
    .errFlag(errFlag), .rstReq(rstReq)
  );

  sec_crc_dpath #(.POLY(POLY), .SEED(SEED)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .crcByte(crcByte), .byteMismatch(byteMismatch)
  );

  assign outData = strb.emit ? crcByte : inData;
endmodule

// File: rtl/sec_crc_stage_chk.sv
module sec_crc_stage_chk (
  input logic       clk,
  input logic       rstN,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       errFlag,
  input logic       errClr,
  input logic       rstReq,
  input logic       emit,
  input logic       absorb
);
  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  assert_req_with_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> errFlag);

  assert_flag_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> rstReq);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);

  assert_tail_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (emit && !outReady) |=> (outValid && $stable(outData)));

  assert_no_forward_R5: assert property (@(posedge clk) disable iff (!rstN)
    absorb |-> !outValid);
endmodule

bind sec_crc_stage sec_crc_stage_chk u_chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .outData(outData), .errFlag(errFlag), .errClr(errClr), .rstReq(rstReq),
  .emit(strb.emit), .absorb(strb.absorb)
);

// File: tb/sec_crc_stage_tb.sv
`timescale 1ns/1ps
module sec_crc_stage_tb;
  localparam logic [63:0] POLY = 64'h42F0E1EBA9EA3693;

  logic clk = 1'b0;
  logic rstN, enReq, rdReq, errClr;
  logic inValid, inLast, inReady, outValid, outLast, outReady, errFlag, rstReq;
  logic [7:0] inData, outData;

  int checks = 0;
  int errors = 0;
  int ocnt = 0;
  int rstCnt = 0;
  logic [7:0] obufD [512];
  logic       obufL [512];
  logic [7:0] pay [32];
  logic [7:0] expD [64];
  logic       expL [64];

  always #2 clk = ~clk;

  sec_crc_stage u_dut (
    .clk(clk), .rstN(rstN), .enReq(enReq), .rdReq(rdReq), .errClr(errClr),
    .inValid(inValid), .inData(inData), .inLast(inLast), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outLast(outLast),
    .outReady(outReady), .errFlag(errFlag), .rstReq(rstReq)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (outValid && outReady) begin
        if (ocnt < 512) begin
          obufD[ocnt] = outData;
          obufL[ocnt] = outLast;
        end
        ocnt++;
      end
      if (rstReq) rstCnt++;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] refCrc(input int n);
    logic [63:0] c = '1;
    for (int i = 0; i < n; i++) begin
      c ^= {pay[i], 56'b0};
      for (int b = 0; b < 8; b++) c = c[63] ? ((c << 1) ^ POLY) : (c << 1);
    end
    return c;
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic l);
    bit ok;
    inValid = 1'b1; inData = b; inLast = l;
    do begin
      @(negedge clk); ok = inReady;
      @(posedge clk); #1;
    end while (!ok);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic sendPayload(input int n);
    for (int i = 0; i < n; i++) sendByte(pay[i], i == n - 1);
  endtask

  task automatic setCfg(input logic en, input logic rd);
    enReq = en; rdReq = rd;
    cycles(2);
  endtask

  task automatic buildWriteExp(input int n, input logic [63:0] crc);
    for (int i = 0; i < n; i++) begin expD[i] = pay[i]; expL[i] = 1'b0; end
    for (int k = 0; k < 8; k++) begin
      expD[n+k] = crc[63-8*k -: 8];
      expL[n+k] = (k == 7);
    end
  endtask

  task automatic cmpStream(input int base, input int n, input string req);
    check(ocnt - base == n, {req, " byte count"}, ocnt - base, n);
    for (int i = 0; i < n; i++) begin
      check(obufD[base+i] == expD[i], {req, " data"}, obufD[base+i], expD[i]);
      check(obufL[base+i] == expL[i], {req, " last"}, obufL[base+i], expL[i]);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid", outValid, 0);
    check(errFlag == 1'b0, "R1 errFlag", errFlag, 0);
    check(rstReq == 1'b0, "R1 rstReq", rstReq, 0);
    cycles(1);
  endtask

  task automatic testPassthrough();
    int base = ocnt;
    setCfg(1'b0, 1'b0);
    pay[0] = 8'hA5; pay[1] = 8'h00; pay[2] = 8'hFF;
    sendPayload(3);
    cycles(3);
    for (int i = 0; i < 3; i++) begin expD[i] = pay[i]; expL[i] = (i == 2); end
    cmpStream(base, 3, "R2 passthrough");
  endtask

  task automatic testWriteKnown();
    int base = ocnt;
    setCfg(1'b1, 1'b0);
    for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
    check(refCrc(9) == 64'h9D13A61C0E5B0FF5, "R4 model", refCrc(9), 64'h9D13A61C0E5B0FF5);
    sendPayload(9);
    cycles(12);
    buildWriteExp(9, 64'h9D13A61C0E5B0FF5);
    cmpStream(base, 17, "R4 known value");
  endtask

  task automatic testWriteTwoSectors();
    int base;
    for (int i = 0; i < 5; i++) pay[i] = 8'h10 * 8'(i) + 8'h3;
    buildWriteExp(5, refCrc(5));
    for (int s = 0; s < 2; s++) begin
      base = ocnt;
      sendPayload(5);
      cycles(12);
      cmpStream(base, 13, "R3 R4 sector insert");
    end
  endtask

  task automatic testBackpressure();
    int base = ocnt;
    logic [63:0] crc;
    pay[0] = 8'h5A; pay[1] = 8'hC3;
    crc = refCrc(2);
    sendPayload(2);
    outReady = 1'b0;
    cycles(4);
    @(negedge clk);
    check(outValid == 1'b1, "R10 valid held", outValid, 1);
    check(outData == crc[63:56], "R10 data held", outData, crc[63:56]);
    check(inReady == 1'b0, "R3 input stalled during CRC", inReady, 0);
    check(ocnt - base == 2, "R10 no byte moved", ocnt - base, 2);
    @(posedge clk); #1;
    outReady = 1'b1;
    cycles(12);
    buildWriteExp(2, crc);
    cmpStream(base, 10, "R10 after release");
  endtask

  task automatic testRead(input bit corrupt);
    int base = ocnt;
    int r0 = rstCnt;
    logic [63:0] crc;
    setCfg(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) pay[i] = 8'h77 ^ 8'(i * 29);
    crc = refCrc(4);
    if (corrupt) crc[23:16] = ~crc[23:16];
    sendPayload(4);
    for (int k = 0; k < 8; k++) sendByte(crc[63-8*k -: 8], 1'b0);
    @(negedge clk);
    if (corrupt) begin
      check(rstReq == 1'b1, "R7 reset request due", rstReq, 1);
      check(errFlag == 1'b1, "R7 error flag set", errFlag, 1);
    end else begin
      check(rstReq == 1'b0, "R6 no reset request", rstReq, 0);
      check(errFlag == 1'b0, "R6 no error", errFlag, 0);
    end
    @(negedge clk);
    check(rstReq == 1'b0, "R7 request one cycle", rstReq, 0);
    check(rstCnt - r0 == (corrupt ? 1 : 0), "R7 pulse count", rstCnt - r0, corrupt ? 1 : 0);
    cycles(1);
    for (int i = 0; i < 4; i++) begin expD[i] = pay[i]; expL[i] = (i == 3); end
    cmpStream(base, 4, "R5 read forward");
  endtask

  task automatic testSticky();
    cycles(5);
    @(negedge clk);
    check(errFlag == 1'b1, "R8 flag sticky", errFlag, 1);
    @(posedge clk); #1;
    errClr = 1'b1;
    @(posedge clk); #1;
    errClr = 1'b0;
    @(negedge clk);
    check(errFlag == 1'b0, "R8 flag cleared", errFlag, 0);
    cycles(1);
  endtask

  task automatic testMidSectorChange();
    int base;
    setCfg(1'b1, 1'b0);
    base = ocnt;
    pay[0] = 8'h01; pay[1] = 8'h02; pay[2] = 8'h03;
    sendByte(pay[0], 1'b0);
    sendByte(pay[1], 1'b0);
    enReq = 1'b0; rdReq = 1'b1;
    cycles(3);
    sendByte(pay[2], 1'b1);
    cycles(12);
    buildWriteExp(3, refCrc(3));
    cmpStream(base, 11, "R9 change ignored mid-sector");
    base = ocnt;
    cycles(2);
    pay[0] = 8'hEE; pay[1] = 8'hDD;
    sendPayload(2);
    cycles(3);
    for (int i = 0; i < 2; i++) begin expD[i] = pay[i]; expL[i] = (i == 1); end
    cmpStream(base, 2, "R9 change applied next sector");
  endtask

  initial begin
    rstN = 1'b0; enReq = 1'b0; rdReq = 1'b0; errClr = 1'b0;
    inValid = 1'b0; inData = '0; inLast = 1'b0; outReady = 1'b1;
    cycles(4);
    rstN = 1'b1;
    testReset();
    testPassthrough();
    testWriteKnown();
    testWriteTwoSectors();
    testBackpressure();
    testRead(1'b0);
    testRead(1'b1);
    testSticky();
    testMidSectorChange();
    summary();
    $finish;
  end
endmodule